// File: doc/BRIEF.md
# Addressable Scan Bridge Selection Controller

This block is the selection logic for a scan bridge that shares a backplane test bus with many identical bridges. All bridges see the same TCK, TMS and TDI traffic, and each bridge runs its own TAP state machine. While a bridge is waiting for an address, the byte shifted through its 8-bit instruction register is treated as a target address. At Update-IR, that address is compared with the bridge's six slot-ID pins. The bridge that matches becomes selected, and every other bridge drops out.

Only a selected bridge drives TDO. A test master that reads back from an empty or unselected slot therefore sees all ones, because TDI has a pull-up. A 2-bit group register lets several bridges be selected at the same time. Addresses 0x3C to 0x3F are multicast addresses, one for each group value. A bridge in a multicast selection never drives TDO, so selected boards cannot fight on the shared return line. A go-to-wait instruction returns every bridge to address waiting.

States: Wait (address waiting), Selected, Multicast, Idle (unselected). Transitions: Wait to Selected on a slot match, Wait to Multicast on a group match, Wait to Idle on any other address, Selected, Multicast or Idle to Wait on go-to-wait, and any state to Wait on TAP reset or TRST_N.

Top module: `scan_bridge_sel`

## Requirements
- R1: TRST_N low, or the TAP in its reset state at a rising TCK, forces Wait, clears the group register to 00 and drives selected, mcast and tdo_en low.
- R2: In Wait, an Update-IR with the register holding {00, slot_id} moves the bridge to Selected, and selected reads 1. This applies to slot IDs outside 0x3C to 0x3F.
- R3: In Wait, an Update-IR with any address that matches neither the slot nor the multicast group moves the bridge to Idle. Later addresses do not select it again until go-to-wait.
- R4: Capture-IR loads {slot_id, 01} into the instruction register (bit 0 = 1, bit 1 = 0, bits 7:2 = slot_id). Shift-IR presents it on TDO least significant bit first.
- R5: tdo_en is high only in Selected while the TAP is in Shift-IR or Shift-DR. It is low in Wait, Idle and Multicast.
- R6: Instruction 0xC1 at Update-IR returns a bridge in Selected, Multicast or Idle to Wait.
- R7: With instruction 0xC2 active, the data path is the 2-bit group register. Capture-DR loads the current group, Shift-DR shifts toward TDO from bit 0, and Update-DR writes the last two bits shifted in. With any other instruction, the data path is a one-stage bypass that captures 0.
- R8: In Wait, address 0x3C+g moves the bridge to Multicast if its group register equals g, and to Idle otherwise. These four addresses never count as a slot match.
- R9: Instructions are honoured only in Selected or Multicast. A 0xC2 shifted while in Idle does not change the group register. While in Selected, any byte other than 0xC1 is taken as an instruction and does not change the selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in (pulled up on the bus) |
| slot_id | input | 6 | Slot identity pins of this bridge |
| tdo | output | 1 | Serial test data out |
| tdo_en | output | 1 | Output enable for tdo |
| selected | output | 1 | High in Selected |
| mcast | output | 1 | High in Multicast |

## Verification
The assertions make four assumptions. TRST_N is held low across at least one rising TCK edge and is released away from an edge. The slot pins are steady around a Capture-IR edge. TMS and TDI settle between edges. The register values they check are counted from the first edge after reset. The bench drives TMS, TDI and TRST_N only at falling TCK edges. It changes the slot pins only while the model is in Wait and the TAP idles. It models the pulled-up bus by reading all ones whenever tdo_en is low.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;
    localparam int IR_W   = 8;
    localparam int GRP_W  = 2;
    localparam int TAG_W  = 2;
    localparam int SLOT_W = IR_W - TAG_W;

    localparam logic [TAG_W-1:0] CAP_TAG    = 2'b01;
    localparam logic [IR_W-1:0]  MC_BASE    = 8'h3C;
    localparam logic [IR_W-1:0]  INS_GOWAIT = 8'hC1;
    localparam logic [IR_W-1:0]  INS_GRPSEL = 8'hC2;
    localparam logic [IR_W-1:0]  INS_BYPASS = 8'hFF;

    typedef enum logic [3:0] {
        TAP_RESET, TAP_IDLE,
        TAP_SELDR, TAP_CAPDR, TAP_SHDR, TAP_EX1DR, TAP_PAUDR, TAP_EX2DR, TAP_UPDDR,
        TAP_SELIR, TAP_CAPIR, TAP_SHIR, TAP_EX1IR, TAP_PAUIR, TAP_EX2IR, TAP_UPDIR
    } tap_st_t;

    typedef enum logic [1:0] {
        SS_WAIT, SS_SEL, SS_MCAST, SS_IDLE
    } sel_st_t;
endpackage

// File: rtl/sbs_tap_fsm.sv
`timescale 1ns/1ps
module sbs_tap_fsm
    import sbs_pkg::*;
(
    input  logic    tck,
    input  logic    trst_n,
    input  logic    tms,
    output tap_st_t state
);
    tap_st_t nxt;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= TAP_RESET;
        else         state <= nxt;
    end

    always_comb begin
        unique case (state)
            TAP_RESET: nxt = tms ? TAP_RESET : TAP_IDLE;
            TAP_IDLE:  nxt = tms ? TAP_SELDR : TAP_IDLE;
            TAP_SELDR: nxt = tms ? TAP_SELIR : TAP_CAPDR;
            TAP_CAPDR: nxt = tms ? TAP_EX1DR : TAP_SHDR;
            TAP_SHDR:  nxt = tms ? TAP_EX1DR : TAP_SHDR;
            TAP_EX1DR: nxt = tms ? TAP_UPDDR : TAP_PAUDR;
            TAP_PAUDR: nxt = tms ? TAP_EX2DR : TAP_PAUDR;
            TAP_EX2DR: nxt = tms ? TAP_UPDDR : TAP_SHDR;
            TAP_UPDDR: nxt = tms ? TAP_SELDR : TAP_IDLE;
            TAP_SELIR: nxt = tms ? TAP_RESET : TAP_CAPIR;
            TAP_CAPIR: nxt = tms ? TAP_EX1IR : TAP_SHIR;
            TAP_SHIR:  nxt = tms ? TAP_EX1IR : TAP_SHIR;
            TAP_EX1IR: nxt = tms ? TAP_UPDIR : TAP_PAUIR;
            TAP_PAUIR: nxt = tms ? TAP_EX2IR : TAP_PAUIR;
            TAP_EX2IR: nxt = tms ? TAP_UPDIR : TAP_SHIR;
            TAP_UPDIR: nxt = tms ? TAP_SELDR : TAP_IDLE;
        endcase
    end
endmodule

// File: rtl/sbs_shifter.sv
`timescale 1ns/1ps
module sbs_shifter
    import sbs_pkg::*;
(
    input  logic              tck,
    input  logic              trst_n,
    input  tap_st_t           tap,
    input  logic              tdi,
    input  logic [SLOT_W-1:0] slot_id,
    input  logic [GRP_W-1:0]  grp,
    input  logic              dr_grp,
    output logic [IR_W-1:0]   ir_sr,
    output logic [GRP_W-1:0]  gsr,
    output logic              tdo
);
    logic byp_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sr <= INS_BYPASS;
            gsr   <= '0;
            byp_q <= 1'b0;
        end else begin
            case (tap)
                TAP_CAPIR: ir_sr <= {slot_id, CAP_TAG};
                TAP_SHIR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                TAP_CAPDR: begin
                    gsr   <= grp;
                    byp_q <= 1'b0;
                end
                TAP_SHDR: begin
                    gsr   <= {tdi, gsr[GRP_W-1:1]};
                    byp_q <= tdi;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        if (tap == TAP_SHIR)      tdo = ir_sr[0];
        else if (tap == TAP_SHDR) tdo = dr_grp ? gsr[0] : byp_q;
        else                      tdo = 1'b1;
    end
endmodule

// File: rtl/sbs_sel_ctrl.sv
`timescale 1ns/1ps
module sbs_sel_ctrl
    import sbs_pkg::*;
(
    input  logic              tck,
    input  logic              trst_n,
    input  tap_st_t           tap,
    input  logic [IR_W-1:0]   ir_sr,
    input  logic [SLOT_W-1:0] slot_id,
    input  logic [GRP_W-1:0]  gsr,
    output sel_st_t           sel,
    output logic [IR_W-1:0]   instr,
    output logic [GRP_W-1:0]  grp
);
    sel_st_t              sel_nxt;
    logic [IR_W-1:0]      instr_nxt;
    logic [GRP_W-1:0]     grp_nxt;
    logic                 is_mc, slot_hit, gowait, honoured;

    assign is_mc    = ir_sr[IR_W-1:GRP_W] == MC_BASE[IR_W-1:GRP_W];
    assign slot_hit = ir_sr == {{TAG_W{1'b0}}, slot_id};
    assign gowait   = ir_sr == INS_GOWAIT;
    assign honoured = (sel == SS_SEL) || (sel == SS_MCAST);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sel   <= SS_WAIT;
            instr <= INS_BYPASS;
            grp   <= '0;
        end else begin
            sel   <= sel_nxt;
            instr <= instr_nxt;
            grp   <= grp_nxt;
        end
    end

    always_comb begin
        sel_nxt   = sel;
        instr_nxt = instr;
        grp_nxt   = grp;
        if (tap == TAP_RESET) begin
            sel_nxt   = SS_WAIT;
            instr_nxt = INS_BYPASS;
            grp_nxt   = '0;
        end else if (tap == TAP_UPDIR) begin
            unique case (sel)
                SS_WAIT: begin
                    if (is_mc)         sel_nxt = (ir_sr[GRP_W-1:0] == grp) ? SS_MCAST : SS_IDLE;
                    else if (slot_hit) sel_nxt = SS_SEL;
                    else               sel_nxt = SS_IDLE;
                end
                SS_SEL, SS_MCAST: begin
                    if (gowait) begin
                        sel_nxt   = SS_WAIT;
                        instr_nxt = INS_BYPASS;
                    end else begin
                        instr_nxt = ir_sr;
                    end
                end
                SS_IDLE: begin
                    if (gowait) sel_nxt = SS_WAIT;
                end
            endcase
        end else if (tap == TAP_UPDDR && honoured && instr == INS_GRPSEL) begin
            grp_nxt = gsr;
        end
    end
endmodule

// File: rtl/scan_bridge_sel.sv
`timescale 1ns/1ps
module scan_bridge_sel
    import sbs_pkg::*;
(
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    input  logic [SLOT_W-1:0] slot_id,
    output logic              tdo,
    output logic              tdo_en,
    output logic              selected,
    output logic              mcast
);
    tap_st_t          tap_q;
    sel_st_t          sel_q;
    logic [IR_W-1:0]  ir_q;
    logic [IR_W-1:0]  instr_q;
    logic [GRP_W-1:0] grp_q;
    logic [GRP_W-1:0] gsr_q;
    logic             dr_grp;

    assign dr_grp = instr_q == INS_GRPSEL;

    sbs_tap_fsm u_tap (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(tap_q)
    );

    sbs_shifter u_shift (
        .tck(tck), .trst_n(trst_n), .tap(tap_q), .tdi(tdi), .slot_id(slot_id),
        .grp(grp_q), .dr_grp(dr_grp), .ir_sr(ir_q), .gsr(gsr_q), .tdo(tdo)
    );

    sbs_sel_ctrl u_sel (
        .tck(tck), .trst_n(trst_n), .tap(tap_q), .ir_sr(ir_q), .slot_id(slot_id),
        .gsr(gsr_q), .sel(sel_q), .instr(instr_q), .grp(grp_q)
    );

    always_comb begin
        selected = sel_q == SS_SEL;
        mcast    = sel_q == SS_MCAST;
        tdo_en   = (sel_q == SS_SEL) && (tap_q == TAP_SHIR || tap_q == TAP_SHDR);
    end
endmodule

// File: rtl/sbs_sel_chk.sv
`timescale 1ns/1ps
module sbs_sel_chk
    import sbs_pkg::*;
(
    input logic              tck,
    input logic              trst_n,
    input tap_st_t           tap,
    input logic [SLOT_W-1:0] slot_id,
    input logic [IR_W-1:0]   ir_sr,
    input logic [GRP_W-1:0]  grp,
    input logic              selected,
    input logic              mcast
);
    assert_reset_clears_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (tap == TAP_RESET) |=> (!selected && !mcast && grp == '0));

    assert_select_on_update_R2: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(selected) |-> ($past(tap) == TAP_UPDIR));

    assert_capture_id_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (tap == TAP_CAPIR) |=> (ir_sr == {$past(slot_id), CAP_TAG}));

    assert_gowait_R6: assert property (@(posedge tck) disable iff (!trst_n)
        (tap == TAP_UPDIR && ir_sr == INS_GOWAIT) |=> (!selected && !mcast));

    assert_grp_write_R7: assert property (@(posedge tck) disable iff (!trst_n)
        (grp != $past(grp)) |-> ($past(tap) == TAP_UPDDR || $past(tap) == TAP_RESET));
endmodule

bind scan_bridge_sel sbs_sel_chk u_chk (
    .tck(tck), .trst_n(trst_n), .tap(tap_q), .slot_id(slot_id),
    .ir_sr(ir_q), .grp(grp_q), .selected(selected), .mcast(mcast)
);

// File: tb/tb_scan_bridge_sel.sv
`timescale 1ns/1ps
module tb_scan_bridge_sel;
    import sbs_pkg::*;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic [5:0] slot_id = 6'd5;
    logic tdo, tdo_en, selected, mcast;

    scan_bridge_sel dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .slot_id(slot_id),
        .tdo(tdo), .tdo_en(tdo_en), .selected(selected), .mcast(mcast)
    );

    always #2.5 tck = ~tck;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    localparam int MW = 0, MS = 1, MM = 2, MU = 3;
    int         m_st = MW;
    logic [1:0] m_grp = 2'b00;
    logic [7:0] m_ins = 8'hFF;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o, output logic e);
        @(negedge tck);
        tms = m; tdi = d;
        #1;
        e = tdo_en;
        o = tdo_en ? tdo : 1'b1;
        @(posedge tck);
    endtask

    function automatic void model_reset();
        m_st = MW; m_grp = 2'b00; m_ins = 8'hFF;
    endfunction

    function automatic void model_ir(input logic [7:0] v);
        if (m_st == MW) begin
            if (v[7:2] == 6'h0F)              m_st = (v[1:0] == m_grp) ? MM : MU;
            else if (v == {2'b00, slot_id})   m_st = MS;
            else                              m_st = MU;
        end else if (v == 8'hC1) begin
            m_st = MW; m_ins = 8'hFF;
        end else if (m_st == MS || m_st == MM) begin
            m_ins = v;
        end
    endfunction

    task automatic do_ir(input logic [7:0] v, input string req);
        logic [7:0] got, ens, exp_rd;
        logic o, e;
        bit drive;
        exp_rd = (m_st == MS) ? {slot_id, 2'b01} : 8'hFF;
        drive  = (m_st == MS);
        step(1, 0, o, e); step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
        for (int i = 0; i < 8; i++) begin
            step(i == 7, v[i], o, e);
            got[i] = o; ens[i] = e;
        end
        step(1, 0, o, e); step(0, 0, o, e);
        model_ir(v);
        #1;
        check({req, " ir readback"}, got, exp_rd);
        check("R5 tdo_en in Shift-IR", ens, drive ? 8'hFF : 8'h00);
        check({req, " status"}, {selected, mcast}, {m_st == MS, m_st == MM});
    endtask

    task automatic do_dr(input logic [3:0] v, input string req);
        logic [3:0] got, ens, exp_rd;
        logic o, e;
        bit drive;
        if (m_st != MS)          exp_rd = 4'hF;
        else if (m_ins == 8'hC2) exp_rd = {v[1:0], m_grp};
        else                     exp_rd = {v[2:0], 1'b0};
        drive = (m_st == MS);
        step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, v[i], o, e);
            got[i] = o; ens[i] = e;
        end
        step(1, 0, o, e); step(0, 0, o, e);
        if ((m_st == MS || m_st == MM) && m_ins == 8'hC2) m_grp = v[3:2];
        #1;
        check({req, " dr readback"}, got, exp_rd);
        check("R5 tdo_en in Shift-DR", ens, drive ? 4'hF : 4'h0);
    endtask

    task automatic tap_reset(input string req);
        logic o, e;
        for (int i = 0; i < 5; i++) step(1, 0, o, e);
        step(0, 0, o, e);
        model_reset();
        #1;
        check({req, " after TAP reset"}, {selected, mcast, tdo_en}, 3'b000);
    endtask

    task automatic pulse_trst(input string req);
        logic o, e;
        @(negedge tck); trst_n = 1'b0;
        @(posedge tck); #1;
        check({req, " during TRST_N"}, {selected, mcast, tdo_en}, 3'b000);
        @(negedge tck); trst_n = 1'b1;
        step(0, 0, o, e);
        model_reset();
    endtask

    initial begin
        int unsigned r;
        logic o, e;
        r = $urandom(32'h5EED);
        @(posedge tck); @(posedge tck); #1;
        check("R1 reset outputs", {selected, mcast, tdo_en}, 3'b000);
        @(negedge tck); trst_n = 1'b1;
        step(0, 0, o, e);

        do_ir(8'h05, "R2 slot match");
        do_ir(8'hC2, "R4 capture id");
        do_dr(4'b1000, "R7 group write");
        do_dr(4'b0100, "R7 group readback");
        do_ir(8'h07, "R9 address while selected");
        do_dr(4'b1011, "R7 bypass");
        do_ir(8'hC1, "R6 go wait from selected");
        do_ir(8'h3D, "R8 multicast hit");
        do_ir(8'hC1, "R6 go wait from multicast");
        do_ir(8'h3E, "R8 multicast miss");
        do_ir(8'h05, "R3 no reselect");
        do_ir(8'hC2, "R9 ignored in idle");
        do_dr(4'b1100, "R9 dr in idle");
        do_ir(8'hC1, "R6 go wait from idle");
        do_ir(8'h3D, "R9 group unchanged");
        do_ir(8'hC1, "R6 leave");
        do_ir(8'h2A, "R3 mismatch");
        do_ir(8'hC1, "R6 leave");
        @(negedge tck); slot_id = 6'h3D;
        do_ir(8'h3D, "R8 reserved slot");
        do_ir(8'hC1, "R6 leave");
        @(negedge tck); slot_id = 6'd5;
        do_ir(8'h05, "R2 select");
        do_ir(8'hC2, "R7 select group");
        do_dr(4'b1100, "R7 write 3");
        tap_reset("R1");
        do_ir(8'h3C, "R1 group cleared");
        pulse_trst("R1");
        do_ir(8'h3C, "R1 after trst");

        for (int n = 0; n < 300; n++) begin
            r = $urandom % 20;
            if (r < 7) begin
                int unsigned k = $urandom % 3;
                logic [7:0] a;
                a = (k == 0) ? {2'b00, slot_id} : (k == 1) ? (8'h3C | 8'($urandom % 4)) : 8'($urandom);
                do_ir(a, (k == 1) ? "R8 rnd" : (k == 0) ? "R2 rnd" : "R3 rnd");
            end else if (r < 10) do_ir(8'hC1, "R6 rnd");
            else if (r < 12)     do_ir(8'hC2, "R9 rnd");
            else if (r < 16)     do_dr(4'($urandom), "R7 rnd");
            else if (r < 17)     do_ir(8'($urandom), "R9 rnd other");
            else if (r < 18)     tap_reset("R1 rnd");
            else if (m_st == MW) begin
                @(negedge tck); slot_id = 6'($urandom % 60);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge tck);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule